// File: doc/BRIEF.md
# Transmit Packet Sync Framer

This block sits in front of a byte-wide modulator and turns an incoming byte stream into fixed-length frames for a block outer code. Each frame begins with a sync byte and continues with the payload. It ends with a run of reserved slots where a downstream encoder writes its parity. Every output byte carries a two-bit tag that names its kind, so later stages can tell sync, payload and parity slots apart without counting.

Two framing modes are selected by `cfg_int_mode`. With the pin high, the host supplies payload only: the block inserts a fixed sync byte (parameter `SYNC_VAL`, default 8'h47) and frames hold 238 payload bytes. With the pin low, the host marks its own sync byte with `in_sync` and frames hold 223 payload bytes. In that mode the block also watches the flag for misalignment and raises a sticky error when it finds one. In both modes 16 parity slots follow the payload. The mode is read only when a frame starts.

Both data sides are valid/ready streams. An input byte is taken on a clock edge where `in_valid` and `in_ready` are both high. An output byte leaves on an edge where `out_valid` and `out_ready` are both high. A byte offered on either side stays unchanged until it is taken. `in_ready` goes low whenever the block has no use for host data: during the parity slots, during an inserted sync slot, and while the output register is full and stalled. Data bit 0 is the least significant bit.

Top module: `tpf_framer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `align_err` are 0, and both stay 0 until the first clock edge after reset is released.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_kind` hold their values on the next cycle.
- R3: In internal mode a frame is 255 bytes: one sync byte of value `SYNC_VAL` (8'h47) that takes no host byte, then 238 host bytes in arrival order, then 16 parity slots of value 8'h00. In this mode `in_sync` is ignored.
- R4: In external mode a frame is 240 bytes: the host byte flagged with `in_sync`=1, forwarded as the sync byte, then 223 host bytes in order, then 16 parity slots of value 8'h00.
- R5: `out_kind` is 2'd0 for a sync byte, 2'd1 for a payload byte and 2'd2 for a parity slot.
- R6: `in_ready` is 0 during parity slots and during an internal-mode sync slot. It is 1 at an external-mode sync slot and at payload slots whenever the output register can accept a byte.
- R7: In external mode, a flagged byte that arrives in a payload slot sets `align_err`. That byte is emitted as a sync byte, and the next byte starts a new payload count.
- R8: In external mode, an unflagged byte offered at the sync slot is accepted and dropped, no output is produced for it, and `align_err` is set.
- R9: A change of `cfg_int_mode` during a frame takes effect only at the start of the next frame.
- R10: Once set, `align_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_int_mode | input | 1 | 1 = block inserts sync byte, 0 = host flags sync byte |
| in_data | input | 8 | Host byte |
| in_valid | input | 1 | Host byte present |
| in_sync | input | 1 | Host marks this byte as sync (external mode) |
| in_ready | output | 1 | Block takes the host byte this edge |
| out_data | output | 8 | Framed byte |
| out_kind | output | 2 | 0 sync, 1 payload, 2 parity slot |
| out_valid | output | 1 | Framed byte present |
| out_ready | input | 1 | Downstream takes the framed byte |
| align_err | output | 1 | Sticky misalignment seen in external mode |

## Verification
A slot counter that drifts would show at the ports within one frame: a sync or parity tag in the wrong place, or a payload run that is too short or too long. The scoreboard catches this on the first misplaced byte. If the frame mode were latched at the wrong time, the next frame would change length, which is caught at its first parity slot. A lost or repeated byte under back-pressure shifts every later payload value, so it is caught on the next compare. Error-flag faults show up in the flag samples taken after each misaligned pattern and after each clean frame.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  typedef enum logic [1:0] {
    KIND_SYNC = 2'd0,
    KIND_PAY  = 2'd1,
    KIND_PAR  = 2'd2
  } kind_e;
endpackage

// File: rtl/tpf_pos_ctr.sv
module tpf_pos_ctr
  import tpf_pkg::*;
#(
  parameter int INT_PAY = 238,
  parameter int EXT_PAY = 223,
  parameter int PAR_LEN = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  restart,
  input  logic  mode_int,
  output kind_e slot_kind,
  output logic  eff_int
);
  localparam int MAX_PAY  = (INT_PAY > EXT_PAY) ? INT_PAY : EXT_PAY;
  localparam int MAX_LAST = MAX_PAY + PAR_LEN;
  localparam int POS_W    = $clog2(MAX_LAST + 1);

  logic [POS_W-1:0] pos_q;
  logic             frame_int_q;
  logic [POS_W-1:0] pay_end;
  logic [POS_W-1:0] last_pos;
  logic             at_start;

  assign at_start = (pos_q == '0);

  always_comb begin
    eff_int  = at_start ? mode_int : frame_int_q;
    pay_end  = eff_int ? POS_W'(INT_PAY) : POS_W'(EXT_PAY);
    last_pos = pay_end + POS_W'(PAR_LEN);
    if (at_start)              slot_kind = KIND_SYNC;
    else if (pos_q <= pay_end) slot_kind = KIND_PAY;
    else                       slot_kind = KIND_PAR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q       <= '0;
      frame_int_q <= 1'b0;
    end else if (restart) begin
      pos_q       <= POS_W'(1);
      frame_int_q <= 1'b0;
    end else if (step) begin
      pos_q <= (pos_q == last_pos) ? '0 : pos_q + POS_W'(1);
      if (at_start) frame_int_q <= mode_int;
    end
  end

  p_pos_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(MAX_LAST));

  p_mode_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!at_start && pos_q != last_pos && !restart) |=> $stable(eff_int));
endmodule

// File: rtl/tpf_out_reg.sv
module tpf_out_reg
  import tpf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  kind_e         ld_kind,
  input  logic          out_ready,
  output logic          can_load,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output kind_e         out_kind
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_kind  <= KIND_SYNC;
    end else if (can_load) begin
      out_valid <= load;
      if (load) begin
        out_data <= ld_data;
        out_kind <= ld_kind;
      end
    end
  end

  p_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind)));
endmodule

// File: rtl/tpf_framer.sv
module tpf_framer
  import tpf_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         INT_PAY  = 238,
  parameter int         EXT_PAY  = 223,
  parameter int         PAR_LEN  = 16,
  parameter logic [7:0] SYNC_VAL = 8'h47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_int_mode,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_sync,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic [1:0]    out_kind,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          align_err
);
  kind_e         slot_kind;
  logic          eff_int;
  logic          can_load;
  logic          needs_in;
  logic          take;
  logic          load;
  logic          step;
  logic          restart;
  logic          set_err;
  logic [DW-1:0] ld_data;
  kind_e         ld_kind;
  kind_e         out_kind_e;

  tpf_pos_ctr #(
    .INT_PAY(INT_PAY), .EXT_PAY(EXT_PAY), .PAR_LEN(PAR_LEN)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(restart),
    .mode_int(cfg_int_mode), .slot_kind(slot_kind), .eff_int(eff_int)
  );

  assign needs_in = (slot_kind == KIND_PAY) || (slot_kind == KIND_SYNC && !eff_int);
  assign in_ready = can_load && needs_in;
  assign take     = in_valid && in_ready;

  always_comb begin
    load    = 1'b0;
    step    = 1'b0;
    restart = 1'b0;
    set_err = 1'b0;
    ld_data = '0;
    ld_kind = slot_kind;
    unique case (slot_kind)
      KIND_SYNC: begin
        if (eff_int) begin
          load    = can_load;
          ld_data = DW'(SYNC_VAL);
          step    = can_load;
        end else if (take) begin
          if (in_sync) begin
            load    = 1'b1;
            ld_data = in_data;
            step    = 1'b1;
          end else begin
            set_err = 1'b1;
          end
        end
      end
      KIND_PAY: begin
        if (take) begin
          load    = 1'b1;
          ld_data = in_data;
          if (!eff_int && in_sync) begin
            ld_kind = KIND_SYNC;
            restart = 1'b1;
            set_err = 1'b1;
          end else begin
            step = 1'b1;
          end
        end
      end
      default: begin
        load = can_load;
        step = can_load;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       align_err <= 1'b0;
    else if (set_err) align_err <= 1'b1;
  end

  tpf_out_reg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_data(ld_data), .ld_kind(ld_kind),
    .out_ready(out_ready), .can_load(can_load), .out_valid(out_valid),
    .out_data(out_data), .out_kind(out_kind_e)
  );
  assign out_kind = out_kind_e;

  p_ready_gap_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kind == KIND_PAR) |-> !in_ready);

  p_int_sync_noin_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (eff_int && slot_kind == KIND_SYNC) |-> !in_ready);

  p_err_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);
endmodule

// File: tb/tb_tpf_framer.sv
`timescale 1ns/1ps
module tb_tpf_framer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_int_mode;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_sync;
  logic       in_ready;
  logic [7:0] out_data;
  logic [1:0] out_kind;
  logic       out_valid;
  logic       out_ready;
  logic       align_err;

  always #4 clk = ~clk;

  tpf_framer dut (
    .clk(clk), .rst_n(rst_n), .cfg_int_mode(cfg_int_mode),
    .in_data(in_data), .in_valid(in_valid), .in_sync(in_sync), .in_ready(in_ready),
    .out_data(out_data), .out_kind(out_kind), .out_valid(out_valid),
    .out_ready(out_ready), .align_err(align_err)
  );

  int         n_chk = 0;
  int         n_bad = 0;
  string      cur_req = "R1";
  logic [9:0] exp_q[$];
  bit         rand_rdy = 1'b0;
  bit         stall_seen = 1'b0;
  logic [9:0] stall_val = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  // downstream ready driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = rand_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  // monitor: R2 hold check and scoreboard compare (R3, R4, R5, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_seen)
        check(out_valid && {out_kind, out_data} == stall_val, "R2",
              {out_valid, out_kind, out_data}, {1'b1, stall_val});
      stall_seen = out_valid && !out_ready;
      stall_val  = {out_kind, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, {cur_req, " unexpected byte"}, {out_kind, out_data}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({out_kind, out_data} == e, {cur_req, "/R5"}, {out_kind, out_data}, e);
        end
      end
    end else begin
      stall_seen = 1'b0;
    end
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 7 + seed * 13 + 1) & 8'hFF);
  endfunction

  task automatic expect_byte(input logic [1:0] k, input logic [7:0] d);
    exp_q.push_back({k, d});
  endtask

  task automatic expect_parity();
    for (int i = 0; i < 16; i++) expect_byte(2'd2, 8'h00);
  endtask

  // entered and left at posedge+1
  task automatic send(input logic [7:0] d, input logic f);
    in_valid = 1'b1; in_data = d; in_sync = f;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sync = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, {cur_req, " drain"}, exp_q.size(), 0);
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic mode, input logic exp_rdy);
    rst_n = 1'b0; cfg_int_mode = mode;
    in_valid = 1'b0; in_sync = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !align_err, "R1 reset", {out_valid, align_err}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !align_err, "R1 after release", {out_valid, align_err}, 0);
    check(in_ready == exp_rdy, "R6 ready at sync slot", in_ready, exp_rdy);
    @(posedge clk); #1;
  endtask

  task automatic int_frame_expect(input int seed);
    expect_byte(2'd0, 8'h47);
    for (int i = 0; i < 238; i++) expect_byte(2'd1, pat(i, seed));
    expect_parity();
  endtask

  task automatic ext_frame(input logic [7:0] s, input int seed);
    expect_byte(2'd0, s);
    for (int i = 0; i < 223; i++) expect_byte(2'd1, pat(i, seed));
    expect_parity();
    send(s, 1'b1);
    for (int i = 0; i < 223; i++) send(pat(i, seed), 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_int_mode = 1'b1;
    in_valid = 1'b0; in_sync = 1'b0; in_data = '0;
    @(posedge clk); #1;

    // internal mode, two frames, back-pressure, in_sync ignored (R3, R6)
    cur_req = "R3"; rand_rdy = 1'b1;
    do_reset(1'b1, 1'b0);
    int_frame_expect(1);
    int_frame_expect(2);
    expect_byte(2'd0, 8'h47);
    for (int i = 0; i < 238; i++) send(pat(i, 1), (i == 5));
    for (int i = 0; i < 238; i++) send(pat(i, 2), 1'b0);
    drain();
    check(!align_err, "R3 no error", align_err, 0);

    // external mode, two frames (R4, R6)
    cur_req = "R4";
    do_reset(1'b0, 1'b1);
    ext_frame(8'hB8, 3);
    ext_frame(8'h1D, 4);
    drain();
    check(!align_err, "R4 no error", align_err, 0);

    // misplaced flag inside payload (R7)
    cur_req = "R7";
    do_reset(1'b0, 1'b1);
    expect_byte(2'd0, 8'hA5);
    for (int i = 0; i < 10; i++) expect_byte(2'd1, pat(i, 5));
    send(8'hA5, 1'b1);
    for (int i = 0; i < 10; i++) send(pat(i, 5), 1'b0);
    check(!align_err, "R7 clean before flag", align_err, 0);
    expect_byte(2'd0, 8'h3C);
    for (int i = 0; i < 223; i++) expect_byte(2'd1, pat(i, 6));
    expect_parity();
    send(8'h3C, 1'b1);
    for (int i = 0; i < 223; i++) send(pat(i, 6), 1'b0);
    drain();
    check(align_err, "R7 error set", align_err, 1);

    // unflagged bytes at sync slot dropped (R8), error sticky (R10)
    cur_req = "R8";
    do_reset(1'b0, 1'b1);
    send(8'h11, 1'b0);
    send(8'h22, 1'b0);
    send(8'h33, 1'b0);
    drain();
    check(align_err, "R8 error set", align_err, 1);
    check(!out_valid, "R8 nothing emitted", out_valid, 0);
    cur_req = "R10";
    ext_frame(8'h6E, 7);
    drain();
    check(align_err, "R10 error stays", align_err, 1);

    // mode change mid-frame applies at next frame (R9)
    cur_req = "R9";
    do_reset(1'b1, 1'b0);
    int_frame_expect(8);
    for (int i = 0; i < 100; i++) send(pat(i, 8), 1'b0);
    cfg_int_mode = 1'b0;
    for (int i = 100; i < 238; i++) send(pat(i, 8), 1'b0);
    ext_frame(8'h5A, 9);
    drain();
    check(!align_err, "R9 no error", align_err, 0);

    // reset clears sticky error (R1)
    cur_req = "R1";
    do_reset(1'b0, 1'b1);
    summary();
  end
endmodule